// File: doc/BRIEF.md
# Dual 32-bit Interval Timer

A memory-mapped peripheral timer with two independent 32-bit counting halves, low and high. Both halves share one tick, which is the core clock divided by a 4-bit value held in the clock-speed word. Each half counts that tick from zero up to its period value. The tick that finds the count equal to the period is a match. A match can raise a one-cycle interrupt, and it drives a timer output that either pulses or toggles.

Each half has a 2-bit run mode: off, single interval or repeating. A half counts only while its release bit in the global word is set. Software re-arms a half by clearing its mode, loading the period, zeroing the count and setting the mode again. Only the two-independent-halves arrangement is built. The chaining, watchdog, external-clock and input-inversion controls are kept as plain storage.

Top module: `dual_timer`

## Requirements
- R1: After reset every register word reads 0, and both irq_o bits and both tout_o bits are 0.
- R2: The word map is 1 clock-speed, 4/5 count low/high, 6/7 period low/high, 8 control, 9 global, 10 watchdog. Words 0, 2, 3 and 11 and above ignore writes and read 0.
- R3: The tick fires once every D core cycles, where D is bits 19:16 of word 1. A D of 0 acts as 1.
- R4: A half's mode field selects how it runs: 10 repeats and 01 runs one interval. The low half's field is at control bits 7:6. In repeat mode with period value P-1, a match occurs every P ticks and the count wraps to 0.
- R5: In single-interval mode (01) the half matches once. The count then holds at the period value, and the hardware clears the half's mode field to 00.
- R6: Mode 00 and mode 11 stop the count where it is. A write to the count word loads it. A half restarted after a reload begins a clean interval.
- R7: While a half's release bit is 0 (global bit 0 for low, bit 1 for high), its count reads 0 and it produces no match.
- R8: A match raises the half's irq_o bit for exactly one cycle, in the cycle after the matching tick. This happens only if the half's interrupt-enable bit is set (control bit 9 for low).
- R9: With the clock/pulse bit at 0 (control bit 3), tout goes high at the match. It stays high for W+1 ticks, where W is the pulse width in control bits 5:4.
- R10: With the clock/pulse bit at 1, tout toggles at each match. The output-invert bit (control bit 1) inverts tout. The status bit (control bit 0) reads the level before inversion.
- R11: The high half behaves like the low half. Its control fields sit 16 bits higher, and its matches leave the low half's outputs unchanged.
- R12: The global mode bits 3:2, the high-half prescale and divide fields, the clock-source and input-invert bits and the watchdog word are stored and read back. They have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Word index |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 2 | Match interrupts, bit 0 low half, bit 1 high half |
| tout_o | output | 2 | Timer outputs, bit 0 low half, bit 1 high half |

## Verification
The assertions on count stability and single-interval completion assume that no bus write lands in the cycle they look at. For that reason they are qualified by we_i being low. They also treat rdata_o as a pure function of addr_i, so the bench drives every access as a single-cycle write strobe. It reads only after the strobe has dropped. Reset is asserted from time zero. Address and data change only on falling edges, so the release and mode fields the assertions watch are always settled registered values.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned N_HALF   = 2;
  localparam int unsigned HALF_OFS = 16;

  localparam int unsigned IDX_CLKSPD = 1;
  localparam int unsigned IDX_CNT_LO = 4;
  localparam int unsigned IDX_PRD_LO = 6;
  localparam int unsigned IDX_CTRL   = 8;
  localparam int unsigned IDX_GCTL   = 9;
  localparam int unsigned IDX_WDCTL  = 10;

  localparam int unsigned B_STAT = 0;
  localparam int unsigned B_INV  = 1;
  localparam int unsigned B_CP   = 3;
  localparam int unsigned B_PW   = 4;
  localparam int unsigned PW_W   = 2;
  localparam int unsigned B_MODE = 6;
  localparam int unsigned B_IEN  = 9;

  localparam int unsigned DIV_LSB = 16;
  localparam int unsigned DIV_W   = 4;

  typedef enum logic [1:0] {
    EN_OFF  = 2'b00,
    EN_ONCE = 2'b01,
    EN_CONT = 2'b10,
    EN_RSVD = 2'b11
  } en_mode_e;
endpackage

// File: rtl/dual_timer_prescale.sv
module dual_timer_prescale #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  // divisor 0 behaves as 1
  assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/dual_timer_counter.sv
module dual_timer_counter
  import dual_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rs_i,
  input  en_mode_e         mode_i,
  input  logic [CNT_W-1:0] prd_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ev_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             active;
  logic             hit;

  assign active = rs_i && (mode_i == EN_ONCE || mode_i == EN_CONT);
  assign hit    = active && tick_i && !ld_i && (cnt_q == prd_i);
  assign ev_o   = hit;
  assign done_o = hit && (mode_i == EN_ONCE);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!rs_i) begin
      cnt_q <= '0;
    end else if (ld_i) begin
      cnt_q <= ld_val_i;
    end else if (active && tick_i) begin
      if (cnt_q == prd_i) begin
        // one-shot holds at the period value
        if (mode_i == EN_CONT) cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dual_timer_outgen.sv
module dual_timer_outgen #(
  parameter int unsigned PW_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            ev_i,
  input  logic            ien_i,
  input  logic            cp_i,
  input  logic [PW_W-1:0] pw_i,
  input  logic            inv_i,
  output logic            irq_o,
  output logic            tout_o,
  output logic            level_o
);
  logic            irq_q;
  logic            level_q;
  logic [PW_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b0;
      level_q <= 1'b0;
      left_q  <= '0;
    end else begin
      irq_q <= ev_i && ien_i;
      if (ev_i) begin
        if (cp_i) begin
          level_q <= ~level_q;
        end else begin
          level_q <= 1'b1;
          left_q  <= pw_i;
        end
      end else if (tick_i && !cp_i && level_q) begin
        if (left_q == '0) level_q <= 1'b0;
        else              left_q  <= left_q - 1'b1;
      end
    end
  end

  assign irq_o   = irq_q;
  assign level_o = level_q;
  assign tout_o  = level_q ^ inv_i;
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dual_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [N_HALF-1:0] irq_o,
  output logic [N_HALF-1:0] tout_o
);
  localparam logic [ADDR_W-1:0] A_CLKSPD = ADDR_W'(IDX_CLKSPD);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(IDX_CTRL);
  localparam logic [ADDR_W-1:0] A_GCTL   = ADDR_W'(IDX_GCTL);
  localparam logic [ADDR_W-1:0] A_WDCTL  = ADDR_W'(IDX_WDCTL);
  localparam logic [WORD_W-1:0] STAT_MASK =
    (WORD_W'(1) << B_STAT) | (WORD_W'(1) << (B_STAT + HALF_OFS));

  logic [WORD_W-1:0]             clkspd_q;
  logic [WORD_W-1:0]             ctrl_q;
  logic [WORD_W-1:0]             gctl_q;
  logic [WORD_W-1:0]             wdctl_q;
  logic [N_HALF-1:0][WORD_W-1:0] prd_q;
  logic [N_HALF-1:0][WORD_W-1:0] cnt_w;
  logic [N_HALF-1:0]             done_w;
  logic [N_HALF-1:0]             ev_w;
  logic [N_HALF-1:0]             level_w;
  logic [WORD_W-1:0]             ctrl_rd;
  logic                          tick_w;

  dual_timer_prescale #(.DIV_W(DIV_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (clkspd_q[DIV_LSB +: DIV_W]),
    .tick_o (tick_w)
  );

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    localparam int unsigned OFS = h * HALF_OFS;
    logic ld;
    assign ld = we_i && (addr_i == ADDR_W'(IDX_CNT_LO + h));

    dual_timer_counter #(.CNT_W(WORD_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_w),
      .rs_i     (gctl_q[h]),
      .mode_i   (en_mode_e'(ctrl_q[OFS + B_MODE +: 2])),
      .prd_i    (prd_q[h]),
      .ld_i     (ld),
      .ld_val_i (wdata_i),
      .cnt_o    (cnt_w[h]),
      .ev_o     (ev_w[h]),
      .done_o   (done_w[h])
    );

    dual_timer_outgen #(.PW_W(PW_W)) u_out (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_w),
      .ev_i    (ev_w[h]),
      .ien_i   (ctrl_q[OFS + B_IEN]),
      .cp_i    (ctrl_q[OFS + B_CP]),
      .pw_i    (ctrl_q[OFS + B_PW +: PW_W]),
      .inv_i   (ctrl_q[OFS + B_INV]),
      .irq_o   (irq_o[h]),
      .tout_o  (tout_o[h]),
      .level_o (level_w[h])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clkspd_q <= '0;
      gctl_q   <= '0;
      wdctl_q  <= '0;
      prd_q    <= '0;
    end else if (we_i) begin
      if (addr_i == A_CLKSPD) clkspd_q <= wdata_i;
      if (addr_i == A_GCTL)   gctl_q   <= wdata_i;
      if (addr_i == A_WDCTL)  wdctl_q  <= wdata_i;
      for (int h = 0; h < N_HALF; h++) begin
        if (addr_i == ADDR_W'(IDX_PRD_LO + h)) prd_q[h] <= wdata_i;
      end
    end
  end

  // software write wins over the one-shot mode clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (we_i && addr_i == A_CTRL) begin
      ctrl_q <= wdata_i & ~STAT_MASK;
    end else begin
      for (int h = 0; h < N_HALF; h++) begin
        if (done_w[h]) ctrl_q[h*HALF_OFS + B_MODE +: 2] <= EN_OFF;
      end
    end
  end

  always_comb begin
    ctrl_rd = ctrl_q;
    for (int h = 0; h < N_HALF; h++) ctrl_rd[h*HALF_OFS + B_STAT] = level_w[h];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CLKSPD) rdata_o = clkspd_q;
    if (addr_i == A_CTRL)   rdata_o = ctrl_rd;
    if (addr_i == A_GCTL)   rdata_o = gctl_q;
    if (addr_i == A_WDCTL)  rdata_o = wdctl_q;
    for (int h = 0; h < N_HALF; h++) begin
      if (addr_i == ADDR_W'(IDX_CNT_LO + h)) rdata_o = cnt_w[h];
      if (addr_i == ADDR_W'(IDX_PRD_LO + h)) rdata_o = prd_q[h];
    end
  end
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
  import dual_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          we_i,
  input logic [ADDR_W-1:0]             addr_i,
  input logic [WORD_W-1:0]             rdata_o,
  input logic [N_HALF-1:0]             irq_o,
  input logic [N_HALF-1:0][1:0]        mode_i,
  input logic [N_HALF-1:0]             ien_i,
  input logic [N_HALF-1:0]             rs_i,
  input logic [N_HALF-1:0][WORD_W-1:0] cnt_i,
  input logic [N_HALF-1:0][WORD_W-1:0] prd_i,
  input logic                          tick_i
);
  p_reserved_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 0 || addr_i == 2 || addr_i == 3 || int'(addr_i) > IDX_WDCTL)
      |-> rdata_o == '0);

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    p_oneshot_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[h] == EN_ONCE && rs_i[h] && tick_i && !we_i && cnt_i[h] == prd_i[h])
        |=> mode_i[h] == EN_OFF);

    p_idle_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((mode_i[h] == EN_OFF || mode_i[h] == EN_RSVD) && rs_i[h] && !we_i)
        |=> $stable(cnt_i[h]));

    p_rs_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rs_i[h] |=> cnt_i[h] == '0);

    p_rs_no_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rs_i[h] |=> !irq_o[h]);

    p_irq_needs_ien_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[h] |-> $past(ien_i[h]));
  end
endmodule

bind dual_timer dual_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .mode_i ({ctrl_q[23:22], ctrl_q[7:6]}),
  .ien_i  ({ctrl_q[25], ctrl_q[9]}),
  .rs_i   (gctl_q[1:0]),
  .cnt_i  (cnt_w),
  .prd_i  (prd_q),
  .tick_i (tick_w)
);

// File: tb/dual_timer_test.sv
module dual_timer_test;
  localparam int CTRL = 8, GCTL = 9, CLKSPD = 1, CNT_LO = 4, PRD_LO = 6, WDCTL = 10;
  localparam logic [31:0] M_ONCE = 32'h40, M_CONT = 32'h80, IEN = 32'h200;
  localparam logic [31:0] CP = 32'h8, INV = 32'h2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq, tout;
  int checks = 0, failures = 0, cyc = 0;

  dual_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .tout_o(tout)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); addr = 4'(a); wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); addr = 4'(a); #1 d = rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_irq(input int h, output int t);
    t = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq[h]) begin t = cyc; break; end
    end
  endtask

  task automatic arm(input int h, input int d, input logic [31:0] p, input logic [31:0] extra);
    wr(CTRL, 0);
    wr(CLKSPD, 32'(d) << 16);
    wr(PRD_LO + h, p);
    wr(CNT_LO + h, 0);
    wr(CTRL, (M_CONT | IEN | extra) << (16 * h));
  endtask

  task automatic count_irq(input int h, input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (irq[h]) c++; end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [31:0] v, v2;
    int t1, t2, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 16; a++) begin rd(a, v); chk("R1 reset word", v, 0); end
    chk("R1 outputs", {30'd0, irq | tout}, 0);

    // R2 map sweep with halves still held (R7: counts stay 0)
    for (int a = 0; a < 16; a++) begin
      logic [31:0] pat, exp;
      pat = 32'hA5A5_5A5A ^ 32'(a);
      if (a == GCTL) pat = pat & ~32'h3;
      wr(a, pat);
      rd(a, v);
      case (a)
        CLKSPD, PRD_LO, PRD_LO + 1, GCTL, WDCTL: exp = pat;
        CTRL: exp = pat & ~32'h0001_0001;
        default: exp = 0; // reserved words, and counts held by R7
      endcase
      chk("R2 R7 map", v, exp);
    end
    for (int a = 0; a < 16; a++) wr(a, 0);
    wr(GCTL, 32'h7);

    // R3 R4 interval sweep, low half
    for (int d = 0; d < 4; d++)
      for (int p = 0; p < 5; p++) begin
        arm(0, d, 32'(p), 0);
        wait_irq(0, t1); wait_irq(0, t2);
        chk("R3 R4 interval", 32'(t2 - t1), 32'((p + 1) * (d == 0 ? 1 : d)));
      end

    // R11 high half sweep, low half quiet
    for (int p = 0; p < 4; p++) begin
      arm(1, 1, 32'(p), 0);
      wait_irq(1, t1); wait_irq(1, t2);
      chk("R11 high interval", 32'(t2 - t1), 32'(p + 1));
    end
    count_irq(0, 30, n);
    chk("R11 low quiet", 32'(n), 0);

    // R5 one-shot
    wr(CTRL, 0); wr(CLKSPD, 32'h1_0000); wr(PRD_LO, 3); wr(CNT_LO, 0);
    wr(CTRL, M_ONCE | IEN);
    count_irq(0, 40, n);
    chk("R5 single event", 32'(n), 1);
    rd(CTRL, v); chk("R5 mode cleared", v & 32'hC0, 0);
    rd(CNT_LO, v); chk("R5 count holds", v, 3);

    // R6 stop, mode 11, re-arm
    arm(0, 1, 1000, 0);
    repeat (20) @(negedge clk);
    wr(CTRL, 0);
    rd(CNT_LO, v); repeat (10) @(negedge clk); rd(CNT_LO, v2);
    chk("R6 stopped count", v2, v);
    wr(CNT_LO, 0); wr(CTRL, 32'hC0);
    repeat (10) @(negedge clk); rd(CNT_LO, v);
    chk("R6 mode 11 idle", v, 0);
    wr(CNT_LO, 32'h55); rd(CNT_LO, v);
    chk("R6 count load", v, 32'h55);
    arm(0, 1, 4, 0);
    wait_irq(0, t1); wait_irq(0, t2);
    chk("R6 re-arm interval", 32'(t2 - t1), 5);

    // R7 release bit low
    wr(GCTL, 32'h6);
    arm(0, 1, 2, 0);
    count_irq(0, 20, n);
    chk("R7 no events", 32'(n), 0);
    rd(CNT_LO, v); chk("R7 count zero", v, 0);
    wr(GCTL, 32'h7);

    // R8 no irq without enable, events still drive tout; irq one cycle wide
    wr(CTRL, 0); wr(PRD_LO, 5); wr(CNT_LO, 0); wr(CTRL, M_CONT);
    n = 0; t1 = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); if (irq[0]) n++; if (tout[0]) t1++;
    end
    chk("R8 masked irq", 32'(n), 0);
    chk("R8 events still run", 32'(t1 > 0), 1);
    arm(0, 1, 4, 0);
    wait_irq(0, t1);
    @(negedge clk);
    chk("R8 irq one cycle", {31'd0, irq[0]}, 0);

    // R9 pulse width sweep
    for (int d = 1; d < 3; d++)
      for (int w = 0; w < 4; w++) begin
        arm(0, d, 20, 32'(w) << 4);
        wait_irq(0, t1);
        n = 0;
        while (tout[0] && n < 100) begin n++; @(negedge clk); end
        chk("R9 pulse width", 32'(n), 32'((w + 1) * d));
      end

    // R10 toggle, status and invert
    arm(0, 1, 4, CP);
    wait_irq(0, t1); v = {31'd0, tout[0]};
    wait_irq(0, t2); v2 = {31'd0, tout[0]};
    chk("R10 toggles", v ^ v2, 1);
    wr(CTRL, 0);
    rd(CTRL, v); chk("R10 status plain", {31'd0, tout[0]}, v & 1);
    wr(CTRL, INV);
    rd(CTRL, v); chk("R10 status inverted", {31'd0, tout[0]}, (v & 1) ^ 1);

    // R12 inert controls
    wr(GCTL, 32'hFF0F); wr(WDCTL, 32'hFFFF_FFFF);
    arm(0, 1, 3, 32'h104);
    wait_irq(0, t1); wait_irq(0, t2);
    chk("R12 inert interval", 32'(t2 - t1), 4);
    rd(GCTL, v); chk("R12 global readback", v, 32'hFF0F);
    rd(WDCTL, v); chk("R12 watchdog readback", v, 32'hFFFF_FFFF);

    finish_up();
  end
endmodule